// File: doc/BRIEF.md
# Receive Bit Clock Recovery with Digital Phase Tracking

This block produces a bit-rate sample strobe for a synchronous serial receiver. It has two sources. In recovery mode it watches the transitions of the incoming data line. It locks a phase counter to the first transition and then trims that counter by one operating sample on every later transition. Each bit period it emits one strobe together with the data value sampled near the middle of the bit. In external mode it takes a receive clock line instead, rejects short glitches on it, and strobes once per accepted rising edge, so the output rate matches the input clock rate.

The operating clock, qualified by an enable, must run at 8, 16 or 32 samples per bit. A two-bit code on the rate input chooses among these ratios at run time. The data line and the external clock line are asynchronous to the operating clock and are synchronized inside the block. A downstream deserializer consumes the strobe and the bit.

Top module: `dpll_rx_clk_rec`

## Requirements
- R1: In recovery mode, once locked and with no further data transitions, a strobe recurs every N enabled operating cycles. Rate code 2'b00 gives N=8, 2'b01 gives N=16 and 2'b10 gives N=32.
- R2: Rate code 2'b11 is reserved and behaves exactly as N=16.
- R3: The block is unlocked after reset and after any change of the rate code, and gives no strobe while unlocked. The first data transition then locks it, and its strobe appears N/2+3 cycles after the transition is driven. A strobe every N cycles follows.
- R4: A locked transition that arrives between 1 and N/2 samples after its expected point is a late transition. It lengthens the current bit by one sample, so the strobe interval across it is N+1.
- R5: A locked transition that arrives between 1 and N/2-1 samples before its expected point is an early transition. It shortens the current bit by one sample, so the strobe interval across it is N-1.
- R6: If a transition is detected in the same cycle as a due sample point, the strobe moves one cycle later. Exactly one strobe is given for that bit, and never two in consecutive cycles.
- R7: bit_val takes the synchronized data value at each strobe and changes at no other time. After reset it is 0.
- R8: In recovery mode the block tracks a stream that has a ±1% rate offset and ±1 sample of edge jitter. The sequence of sampled bits equals the transmitted sequence at every ratio.
- R9: With src_sel=1, each accepted rising edge of ext_clk gives exactly one strobe, at the same rate as ext_clk, and bit_val carries the data value at that moment.
- R10: A new ext_clk level is accepted only after 3 consecutive operating samples agree on it. A pulse lasting 1 or 2 samples gives no strobe.
- R11: While op_en is 0, no strobe is given and all timing state is held. The strobe interval then grows by exactly the number of disabled cycles.
- R12: While reset is applied and right after it, bit_stb and bit_val are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Operating clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_en | input | 1 | Operating sample enable |
| rx_data | input | 1 | Asynchronous serial data in |
| ext_clk | input | 1 | Asynchronous external receive clock |
| rate_sel | input | 2 | Samples-per-bit code (00:8, 01:16, 10:32, 11:16) |
| src_sel | input | 1 | 0: recover from data, 1: filtered external clock |
| bit_stb | output | 1 | One-cycle strobe per received bit |
| bit_val | output | 1 | Data bit captured at the latest strobe |

## Verification
Two things can fall in the same operating cycle: a phase correction from a data transition, and the mid-bit sample point. The bench provokes this by locking at N=8 with a clean alternating pattern. It then delays a single bit boundary by exactly N/2 samples, so that the transition is detected on the cycle the strobe is due. The result passes only if the next strobe arrives N+1 cycles after the previous one, with no second strobe in between. The one-sample early and late cases are measured the same way against N-1 and N+1.

// File: rtl/dpll_pkg.sv
package dpll_pkg;

   typedef enum logic [1:0] {
      RATE_X8   = 2'b00,
      RATE_X16  = 2'b01,
      RATE_X32  = 2'b10,
      RATE_RSVD = 2'b11
   } rate_code_e;

   // log2 of the samples-per-bit ratio; the reserved code maps to x16
   function automatic int ratio_log2(input logic [1:0] code);
      case (rate_code_e'(code))
         RATE_X8:  return 3;
         RATE_X16: return 4;
         RATE_X32: return 5;
         default:  return 4;
      endcase
   endfunction

endpackage

// File: rtl/dpll_sync.sv
module dpll_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   logic [STAGES-1:0] stage_q;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) stage_q[0] <= 1'b0;
               else        stage_q[0] <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) stage_q[i] <= 1'b0;
               else        stage_q[i] <= stage_q[i-1];
            end
         end
      end
   endgenerate

   assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/dpll_glitch_filter.sv
module dpll_glitch_filter #(
   parameter int HOLD = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic din,
   output logic rise
);
   localparam int CW = (HOLD > 2) ? $clog2(HOLD) : 1;

   logic          level_q;
   logic [CW-1:0] run_q;
   logic          differs;
   logic          accept;

   always_comb begin
      differs = din != level_q;
      accept  = en && differs && (run_q == CW'(HOLD - 1));
      rise    = accept && din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         level_q <= 1'b0;
         run_q   <= '0;
      end else if (en) begin
         if (!differs) begin
            run_q <= '0;
         end else if (accept) begin
            level_q <= din;
            run_q   <= '0;
         end else begin
            run_q <= run_q + CW'(1);
         end
      end
   end
endmodule

// File: rtl/dpll_phase_track.sv
module dpll_phase_track
   import dpll_pkg::*;
#(
   parameter int MAX_LOG2 = 5
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  logic       din,
   input  logic [1:0] rate_sel,
   output logic       stb
);
   localparam int PW = MAX_LOG2;

   logic [PW-1:0] ph_q;
   logic          locked_q;
   logic          prev_q;
   logic [1:0]    rate_q;

   logic          edge_seen;
   logic          rate_chg;
   logic          hold_now;
   logic [PW:0]   n_val, half, ph_x, ph_inc, ph_skip;

   always_comb begin
      n_val     = (PW+1)'(1) << ratio_log2(rate_sel);
      half      = n_val >> 1;
      ph_x      = {1'b0, ph_q};
      edge_seen = din ^ prev_q;
      rate_chg  = rate_sel != rate_q;
      // late transition (including one on the sample point): stretch
      hold_now  = locked_q && edge_seen && (ph_x != '0) && (ph_x <= half);
      ph_inc    = ((ph_x + (PW+1)'(1)) >= n_val) ? '0 : ph_x + (PW+1)'(1);
      ph_skip   = ph_x + (PW+1)'(2);
      if (ph_skip >= n_val) ph_skip = ph_skip - n_val;
      stb       = en && locked_q && !rate_chg && (ph_x == half) && !edge_seen;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q     <= '0;
         locked_q <= 1'b0;
         prev_q   <= 1'b0;
         rate_q   <= 2'b00;
      end else if (en) begin
         prev_q <= din;
         rate_q <= rate_sel;
         if (rate_chg) begin
            locked_q <= 1'b0;
            ph_q     <= '0;
         end else if (!locked_q) begin
            if (edge_seen) begin
               locked_q <= 1'b1;
               ph_q     <= PW'(1);
            end
         end else if (edge_seen) begin
            if (ph_x == '0)    ph_q <= ph_inc[PW-1:0];
            else if (hold_now) ph_q <= ph_q;
            else               ph_q <= ph_skip[PW-1:0];
         end else begin
            ph_q <= ph_inc[PW-1:0];
         end
      end
   end
endmodule

// File: rtl/dpll_rx_clk_rec.sv
module dpll_rx_clk_rec
   import dpll_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_HOLD   = 3,
   parameter int MAX_LOG2    = 5
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       op_en,
   input  logic       rx_data,
   input  logic       ext_clk,
   input  logic [1:0] rate_sel,
   input  logic       src_sel,
   output logic       bit_stb,
   output logic       bit_val
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (FILT_HOLD < 2) begin : g_bad_hold
         $error("FILT_HOLD must be at least 2");
      end
      if (MAX_LOG2 < 5) begin : g_bad_log2
         $error("MAX_LOG2 must cover a ratio of 32");
      end
   endgenerate

   logic data_s, ext_s;
   logic dp_stb, ext_rise, take;

   dpll_sync #(.STAGES(SYNC_STAGES)) u_sync_data (
      .clk(clk), .rst_n(rst_n), .din(rx_data), .dout(data_s)
   );

   dpll_sync #(.STAGES(SYNC_STAGES)) u_sync_ext (
      .clk(clk), .rst_n(rst_n), .din(ext_clk), .dout(ext_s)
   );

   dpll_phase_track #(.MAX_LOG2(MAX_LOG2)) u_track (
      .clk(clk), .rst_n(rst_n), .en(op_en), .din(data_s),
      .rate_sel(rate_sel), .stb(dp_stb)
   );

   dpll_glitch_filter #(.HOLD(FILT_HOLD)) u_filt (
      .clk(clk), .rst_n(rst_n), .en(op_en), .din(ext_s), .rise(ext_rise)
   );

   assign take = op_en && (src_sel ? ext_rise : dp_stb);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bit_stb <= 1'b0;
         bit_val <= 1'b0;
      end else begin
         bit_stb <= take;
         if (take) bit_val <= data_s;
      end
   end
endmodule

// File: rtl/dpll_rx_clk_rec_chk.sv
module dpll_rx_clk_rec_chk #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_HOLD   = 3
) (
   input logic clk,
   input logic rst_n,
   input logic op_en,
   input logic ext_clk,
   input logic src_sel,
   input logic bit_stb,
   input logic bit_val
);
   assert_idle_no_stb_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !op_en |=> !bit_stb);

   assert_val_only_on_stb_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_stb |-> $stable(bit_val));

   assert_no_double_stb_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_stb && !src_sel) |=> !(bit_stb && !src_sel));

   generate
      if (SYNC_STAGES == 2 && FILT_HOLD == 3) begin : g_ext_chk
         assert_ext_needs_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (bit_stb && $past(src_sel) && $past(op_en) && $past(op_en, 2) && $past(op_en, 3))
            |-> ($past(ext_clk, 3) && $past(ext_clk, 4) && $past(ext_clk, 5)));
      end
   endgenerate
endmodule

bind dpll_rx_clk_rec dpll_rx_clk_rec_chk #(
   .SYNC_STAGES(SYNC_STAGES),
   .FILT_HOLD(FILT_HOLD)
) u_chk (
   .clk(clk), .rst_n(rst_n), .op_en(op_en), .ext_clk(ext_clk),
   .src_sel(src_sel), .bit_stb(bit_stb), .bit_val(bit_val)
);

// File: tb/dpll_rx_clk_rec_tb.sv
module dpll_rx_clk_rec_tb;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 150000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       op_en = 1'b1;
   logic       rx_data = 1'b0;
   logic       ext_clk = 1'b0;
   logic [1:0] rate_sel = 2'b00;
   logic       src_sel = 1'b0;
   logic       bit_stb, bit_val;

   int n_tests = 0;
   int n_fail  = 0;
   int st[0:63];
   int sc;
   bit rxb[0:63];
   bit txb[0:63];
   int bnd[0:63];
   logic [15:0] lfsr = 16'hACE1;

   always #(CLK_PERIOD/2) clk = ~clk;

   dpll_rx_clk_rec u_dut (
      .clk(clk), .rst_n(rst_n), .op_en(op_en), .rx_data(rx_data),
      .ext_clk(ext_clk), .rate_sel(rate_sel), .src_sel(src_sel),
      .bit_stb(bit_stb), .bit_val(bit_val)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int lfsr_step();
      lfsr = {1'b0, lfsr[15:1]} ^ (lfsr[0] ? 16'hB400 : 16'h0000);
      return int'(lfsr[2:0]);
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; op_en = 1'b1; rx_data = 1'b0; ext_clk = 1'b0;
      rate_sel = 2'b00; src_sel = 1'b0;
      repeat (3) @(negedge clk);
      chk(bit_stb == 1'b0 && bit_val == 1'b0, "R12", "outputs in reset",
          int'({bit_stb, bit_val}), 0);
      rst_n = 1'b1;
   endtask

   // one edge, then constant data: first strobe latency and free-run period
   task automatic t_free_run(input logic [1:0] code, input int n, input string req);
      do_reset();
      rate_sel = code;
      repeat (4) @(negedge clk);
      sc = 0;
      for (int t = 0; t < 6*n + 12; t++) begin
         @(negedge clk);
         if (bit_stb && sc < 64) begin st[sc] = t; sc++; end
         if (t == 0) rx_data = 1'b1;
      end
      chk(sc >= 4 && st[0] == n/2 + 3, "R3", "first strobe delay", st[0], n/2 + 3);
      chk(st[1] - st[0] == n, req, "free-run interval", st[1] - st[0], n);
      chk(st[3] - st[2] == n, req, "later free-run interval", st[3] - st[2], n);
   endtask

   // rate change unlocks, relock on next edge
   task automatic t_rate_change();
      int cnt;
      do_reset();
      for (int t = 0; t < 40; t++) begin
         @(negedge clk);
         if (t == 0) rx_data = 1'b1;
      end
      rate_sel = 2'b01;
      cnt = 0;
      for (int t = 0; t < 60; t++) begin
         @(negedge clk);
         if (bit_stb) cnt++;
      end
      chk(cnt == 0, "R3", "strobes while unlocked", cnt, 0);
      sc = 0;
      for (int t = 0; t < 40; t++) begin
         @(negedge clk);
         if (bit_stb && sc < 64) begin st[sc] = t; sc++; end
         if (t == 0) rx_data = 1'b0;
      end
      chk(sc > 0 && st[0] == 11, "R3", "relock strobe delay at x16", st[0], 11);
   endtask

   // alternating bits at N=8, boundary 6 displaced by d samples
   task automatic t_displace(input int d, input int exp_int, input string req);
      do_reset();
      repeat (4) @(negedge clk);
      sc = 0;
      for (int t = 0; t < 100; t++) begin
         @(negedge clk);
         if (bit_stb && sc < 64) begin st[sc] = t; sc++; end
         for (int k = 0; k < 10; k++) begin
            if (t == ((k == 6) ? 8*k + d : 8*k)) rx_data = ~k[0];
         end
      end
      chk(sc > 6 && st[5] == 47, req, "strobe before displaced edge", st[5], 47);
      chk(sc > 6 && st[6] - st[5] == exp_int, req, "interval across displaced edge",
          st[6] - st[5], exp_int);
   endtask

   // jittered, offset stream; sampled sequence must match
   task automatic t_stream(input logic [1:0] code, input int n, input int per256,
                           input int nbits);
      int k, mism, total;
      do_reset();
      rate_sel = code;
      repeat (4) @(negedge clk);
      txb[0] = 1'b1;
      bnd[0] = 0;
      for (int i = 1; i < nbits; i++) begin
         int j;
         txb[i] = lfsr_step() > 3;
         j = lfsr_step() % 3 - 1;
         bnd[i] = (i * per256) / 256 + j;
      end
      total = (nbits * per256) / 256 + 2*n;
      k = 0; sc = 0;
      for (int t = 0; t < total; t++) begin
         @(negedge clk);
         if (bit_stb && sc < 64) begin rxb[sc] = bit_val; sc++; end
         while (k < nbits && bnd[k] <= t) begin rx_data = txb[k]; k++; end
      end
      chk(sc >= nbits, "R8", "recovered bit count", sc, nbits);
      mism = 0;
      for (int i = 0; i < nbits; i++) if (i < sc && rxb[i] != txb[i]) mism++;
      chk(mism == 0, "R7 R8", "mismatched bits", mism, 0);
   endtask

   task automatic t_ext();
      do_reset();
      src_sel = 1'b1; rx_data = 1'b1;
      repeat (10) @(negedge clk);
      sc = 0;
      for (int t = 0; t < 12*10 + 10; t++) begin
         @(negedge clk);
         if (bit_stb && sc < 64) begin st[sc] = t; sc++; end
         ext_clk = (t < 120) ? ((t % 12) < 6) : 1'b0;
      end
      chk(sc == 10, "R9", "strobes for ten clock periods", sc, 10);
      chk(sc > 3 && st[3] - st[2] == 12, "R9", "strobe interval equals clock period",
          st[3] - st[2], 12);
      chk(bit_val == 1'b1, "R9", "bit captured high", int'(bit_val), 1);
      rx_data = 1'b0;
      for (int t = 0; t < 20; t++) begin
         @(negedge clk);
         ext_clk = (t % 12) < 6;
      end
      chk(bit_val == 1'b0, "R9", "bit captured low", int'(bit_val), 0);
   endtask

   task automatic t_glitch();
      int cnt;
      do_reset();
      src_sel = 1'b1;
      cnt = 0;
      for (int t = 0; t < 40; t++) begin
         @(negedge clk);
         if (bit_stb) cnt++;
         ext_clk = (t == 2) || (t == 10) || (t == 11);
      end
      chk(cnt == 0, "R10", "strobes from short pulses", cnt, 0);
      cnt = 0;
      for (int t = 0; t < 20; t++) begin
         @(negedge clk);
         if (bit_stb) cnt++;
         ext_clk = (t >= 1) && (t <= 3);
      end
      chk(cnt == 1, "R10", "strobes from 3-sample pulse", cnt, 1);
   endtask

   task automatic t_freeze();
      int cnt;
      do_reset();
      repeat (4) @(negedge clk);
      sc = 0; cnt = 0;
      for (int t = 0; t < 90; t++) begin
         @(negedge clk);
         if (bit_stb && sc < 64) begin st[sc] = t; sc++; end
         if (bit_stb && op_en == 1'b0) cnt++;
         if (t == 0) rx_data = 1'b1;
         if (t == 7) op_en = 1'b0;
         if (t == 47) op_en = 1'b1;
      end
      chk(cnt == 0, "R11", "strobes while disabled", cnt, 0);
      chk(sc > 1 && st[1] == 55, "R11", "strobe after freeze", st[1], 55);
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL R8 watchdog: actual %0d cycles expected fewer", WATCHDOG);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      do_reset();
      @(negedge clk);
      chk(bit_stb == 1'b0 && bit_val == 1'b0, "R12", "outputs after reset",
          int'({bit_stb, bit_val}), 0);
      t_free_run(2'b00, 8,  "R1");
      t_free_run(2'b01, 16, "R1");
      t_free_run(2'b10, 32, "R1");
      t_free_run(2'b11, 16, "R2");
      t_rate_change();
      t_displace(0,  8, "R1");
      t_displace(1,  9, "R4");
      t_displace(-1, 7, "R5");
      t_displace(4,  9, "R6");
      t_stream(2'b00, 8,  2068, 40);
      t_stream(2'b01, 16, 4055, 40);
      t_stream(2'b10, 32, 8274, 40);
      t_stream(2'b11, 16, 4137, 40);
      t_ext();
      t_glitch();
      t_freeze();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule